// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block puts a chipset's configuration registers behind a window of four consecutive 8-bit I/O ports. The lowest port holds a register pointer. The next port reads or writes the register that the pointer selects. The upper two ports act on reads and writes alone: one raises or drops the alternate A20 gate, and the other asks the CPU for a soft reset. The data written to those two ports is never used.

Software first writes a register number to the pointer port. It then moves data through the data port. Only a band of low register numbers can be written. Register zero always returns a fixed identification byte. Every other register outside the band reads as zero. The writable band goes out as one flat vector to the memory shadow decoder. The A20 gate is a registered level. The soft-reset request is a registered pulse that lasts one clock.

The bus side is a synchronous strobe interface. `ioRd` and `ioWr` are each high for one clock per access, and they come with an 8-bit port address. Read data is combinational while `ioRd` is high. Register updates, the A20 level and the reset pulse appear after the next rising clock edge.

Top module: `cfgport_top`

## Requirements
- R1: Only the four ports from BASE_PORT (default 0xEC) to BASE_PORT+3 respond. A read of any other port returns 0xFF, and a write to any other port changes no state.
- R2: A write to offset 0 (0xEC) stores the whole 8-bit value as the register pointer. A read of offset 0 returns the pointer.
- R3: A write to offset 1 (0xED) updates the selected register when the pointer lies between WR_LO (0x01) and WR_HI (0x24), both ends included. A later read of offset 1 with the same pointer returns the written value.
- R4: A write to offset 1 while the pointer lies outside the writable band changes no register. Reads of non-ID registers outside the band return 0x00.
- R5: Register 0 always reads as ID_VAL (0x90), and writes to it through offset 1 have no effect.
- R6: A read of offset 2 (0xEE) sets `a20Gate` high from the next clock. A write to offset 2 drives it low from the next clock.
- R7: A read of offset 3 (0xEF) makes `softRst` high for exactly the one clock after that strobe. `softRst` is never high at any other time.
- R8: Reads of offsets 2 and 3 return 0xFF.
- R9: After reset the pointer is 0, every writable register is 0x00, and `a20Gate` and `softRst` are low.
- R10: Byte k of `regWin` (bits k*8+7 down to k*8) holds register WR_LO+k. It changes only after a write to offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioRd | input | 1 | I/O read strobe, one clock per access |
| ioWr | input | 1 | I/O write strobe, one clock per access |
| ioAddr | input | 8 | I/O port address |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, valid while ioRd is high |
| regWin | output | 288 | Writable registers WR_LO..WR_HI, one byte each, for the shadow decoder |
| a20Gate | output | 1 | Alternate A20 gate level |
| softRst | output | 1 | One-clock CPU soft-reset request |

## Verification
The bench uses the default parameters: an 8-bit data path, a base port of 0xEC, and a writable band from 0x01 to 0x24. With these values both ends of the band can be reached, as can the first pointer past the band (0x25) and the largest pointer (0xFF). Addresses that match the window's low two bits but not its upper bits are used to show that partial decode is rejected. The side-effect ports are driven in both directions, and the soft-reset pulse is checked in each clock around the strobe.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  // Strobes from control to datapath, one per decoded access.
  typedef struct packed {
    logic idxWr;   // pointer port written
    logic dataWr;  // data port written
    logic a20Set;  // gate port read
    logic a20Clr;  // gate port written
    logic rstReq;  // reset port read
    logic rdIdx;   // pointer port read
    logic rdData;  // data port read
  } cfgStrobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_PORT = 'hEC
) (
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  output cfgStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_PORT);

  logic       hit;
  logic [1:0] off;

  // The window is four-aligned, so the upper bits select it and the low two bits pick the port.
  assign hit = (ioAddr[ADDR_W-1:2] == BASE_V[ADDR_W-1:2]);
  assign off = ioAddr[1:0];

  always_comb begin
    stb        = '0;
    stb.idxWr  = hit && ioWr && (off == 2'd0);
    stb.dataWr = hit && ioWr && (off == 2'd1);
    stb.a20Clr = hit && ioWr && (off == 2'd2);
    stb.a20Set = hit && ioRd && (off == 2'd2);
    stb.rstReq = hit && ioRd && (off == 2'd3);
    stb.rdIdx  = hit && ioRd && (off == 2'd0);
    stb.rdData = hit && ioRd && (off == 2'd1);
  end
endmodule

// File: rtl/cfgport_dpath.sv
module cfgport_dpath
  import cfgport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WR_LO  = 'h01,
  parameter int WR_HI  = 'h24,
  parameter int ID_VAL = 'h90,
  localparam int WIN   = WR_HI - WR_LO + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            stb,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [WIN*DATA_W-1:0] regWin,
  output logic                  a20Gate,
  output logic                  softRst
);
  localparam int OFF_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [DATA_W-1:0] LO_V = DATA_W'(WR_LO);
  localparam logic [DATA_W-1:0] HI_V = DATA_W'(WR_HI);
  localparam logic [DATA_W-1:0] ID_V = DATA_W'(ID_VAL);

  logic [DATA_W-1:0] idxQ;
  logic [DATA_W-1:0] fileQ [WIN];
  logic [DATA_W-1:0] winOff;
  logic              inWin;
  logic [DATA_W-1:0] regRead;

  always_ff @(posedge clk) begin
    if (!rstN)          idxQ <= '0;
    else if (stb.idxWr) idxQ <= wrData;
  end

  assign inWin  = (idxQ >= LO_V) && (idxQ <= HI_V);
  assign winOff = idxQ - LO_V;

  // Storage exists only for the writable band. Each byte has its own write enable.
  for (genvar g = 0; g < WIN; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        fileQ[g] <= '0;
      else if (stb.dataWr && (idxQ == DATA_W'(WR_LO + g)))
        fileQ[g] <= wrData;
    end
    assign regWin[g*DATA_W +: DATA_W] = fileQ[g];
  end

  always_comb begin
    if (idxQ == '0)  regRead = ID_V;
    else if (inWin)  regRead = fileQ[winOff[OFF_W-1:0]];
    else             regRead = '0;
  end

  always_comb begin
    if (stb.rdIdx)       rdData = idxQ;
    else if (stb.rdData) rdData = regRead;
    else                 rdData = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a20Gate <= 1'b0;
      softRst <= 1'b0;
    end else begin
      softRst <= stb.rstReq;
      if (stb.a20Set)      a20Gate <= 1'b1;
      else if (stb.a20Clr) a20Gate <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BASE_PORT = 'hEC,
  parameter int WR_LO     = 'h01,
  parameter int WR_HI     = 'h24,
  parameter int ID_VAL    = 'h90,
  localparam int WIN      = WR_HI - WR_LO + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioRd,
  input  logic                  ioWr,
  input  logic [7:0]            ioAddr,
  input  logic [DATA_W-1:0]     ioWrData,
  output logic [DATA_W-1:0]     ioRdData,
  output logic [WIN*DATA_W-1:0] regWin,
  output logic                  a20Gate,
  output logic                  softRst
);
  cfgStrobe_t stb;

  cfgport_ctrl #(.ADDR_W(8), .BASE_PORT(BASE_PORT)) uCtrl (
    .ioRd(ioRd), .ioWr(ioWr), .ioAddr(ioAddr), .stb(stb)
  );

  cfgport_dpath #(.DATA_W(DATA_W), .WR_LO(WR_LO), .WR_HI(WR_HI), .ID_VAL(ID_VAL)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(ioWrData), .rdData(ioRdData),
    .regWin(regWin), .a20Gate(a20Gate), .softRst(softRst)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int DATA_W    = 8,
  parameter int BASE_PORT = 'hEC,
  parameter int WIN       = 36
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ioRd,
  input logic                  ioWr,
  input logic [7:0]            ioAddr,
  input logic [DATA_W-1:0]     ioRdData,
  input logic [WIN*DATA_W-1:0] regWin,
  input logic                  a20Gate,
  input logic                  softRst
);
  localparam logic [7:0] B0 = 8'(BASE_PORT);

  // R6
  a20_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == B0 + 8'd2) |=> a20Gate);
  // R6
  a20_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && !ioRd && ioAddr == B0 + 8'd2) |=> !a20Gate);
  // R7
  soft_rst_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> $past(ioRd && ioAddr == B0 + 8'd3));
  // R7
  soft_rst_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == B0 + 8'd3) |=> softRst);
  // R8
  side_port_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr[7:2] == B0[7:2] && ioAddr[1]) |-> (ioRdData == '1));
  // R1
  miss_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr[7:2] != B0[7:2]) |-> (ioRdData == '1));
  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && ioAddr == B0 + 8'd1) |=> $stable(regWin));
endmodule

bind cfgport_top cfgport_chk #(.DATA_W(DATA_W), .BASE_PORT(BASE_PORT), .WIN(WIN)) uChk (
  .clk(clk), .rstN(rstN), .ioRd(ioRd), .ioWr(ioWr), .ioAddr(ioAddr),
  .ioRdData(ioRdData), .regWin(regWin), .a20Gate(a20Gate), .softRst(softRst)
);

// File: tb/sim_cfgport_top.sv
module sim_cfgport_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ioRd = 1'b0;
  logic         ioWr = 1'b0;
  logic [7:0]   ioAddr = 8'h00;
  logic [7:0]   ioWrData = 8'h00;
  logic [7:0]   ioRdData;
  logic [287:0] regWin;
  logic         a20Gate;
  logic         softRst;

  int checks = 0;
  int errors = 0;
  logic [7:0] lastRd;

  always #2.5 clk = ~clk;

  cfgport_top u0 (.*);

  typedef struct packed {
    logic       isRd;
    logic [7:0] addr;
    logic [7:0] data;   // write data, or expected read value
    logic [7:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hEC, 8'h00, 8'd9},   // R9 pointer reset value
    '{1'b1, 8'hED, 8'h90, 8'd5},   // R5 ID read
    '{1'b0, 8'hED, 8'h55, 8'd5},
    '{1'b1, 8'hED, 8'h90, 8'd5},   // R5 ID unchanged after write
    '{1'b0, 8'hEC, 8'h01, 8'd2},
    '{1'b1, 8'hEC, 8'h01, 8'd2},   // R2 pointer readback
    '{1'b0, 8'hED, 8'hA5, 8'd3},
    '{1'b1, 8'hED, 8'hA5, 8'd3},   // R3 low band end
    '{1'b0, 8'hEC, 8'h24, 8'd3},
    '{1'b0, 8'hED, 8'h3C, 8'd3},
    '{1'b1, 8'hED, 8'h3C, 8'd3},   // R3 high band end
    '{1'b0, 8'hEC, 8'h25, 8'd4},
    '{1'b0, 8'hED, 8'h77, 8'd4},
    '{1'b1, 8'hED, 8'h00, 8'd4},   // R4 just past band
    '{1'b0, 8'hEC, 8'hFF, 8'd4},
    '{1'b0, 8'hED, 8'h11, 8'd4},
    '{1'b1, 8'hED, 8'h00, 8'd4},   // R4 top pointer
    '{1'b1, 8'hEC, 8'hFF, 8'd2},   // R2 full 8-bit pointer
    '{1'b0, 8'hEC, 8'h01, 8'd3},
    '{1'b1, 8'hED, 8'hA5, 8'd3},   // R3 value retained
    '{1'b0, 8'h6D, 8'h99, 8'd1},   // R1 alias address write ignored
    '{1'b0, 8'hF0, 8'h02, 8'd1},   // R1 neighbour port write ignored
    '{1'b1, 8'hED, 8'hA5, 8'd1},   // R1 register and pointer untouched
    '{1'b1, 8'hE8, 8'hFF, 8'd1},   // R1 miss read
    '{1'b1, 8'h6C, 8'hFF, 8'd1},   // R1 alias miss read
    '{1'b1, 8'hEE, 8'hFF, 8'd8},   // R8 gate port read value
    '{1'b1, 8'hEF, 8'hFF, 8'd8}    // R8 reset port read value
  };

  task automatic check(input string tag, input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drives one strobe and captures read data.
  // Returns at the next negedge, once registered effects are visible.
  task automatic access(input logic rd, input logic [7:0] addr, input logic [7:0] data);
    ioRd = rd; ioWr = !rd; ioAddr = addr; ioWrData = data;
    #1 lastRd = ioRdData;
    @(negedge clk);
    ioRd = 1'b0; ioWr = 1'b0; ioAddr = 8'h00; ioWrData = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R9 reset state at the ports
    check("R9 a20Gate", 288'(a20Gate), 288'(0));
    check("R9 softRst", 288'(softRst), 288'(0));
    check("R9 regWin", regWin, 288'(0));

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].isRd, VEC[i].addr, VEC[i].data);
      if (VEC[i].isRd)
        check($sformatf("R%0d vector %0d", VEC[i].req, i), 288'(lastRd), 288'(VEC[i].data));
    end

    // R10 window layout: byte 0 is register 0x01, byte 35 is register 0x24
    check("R10 byte0", 288'(regWin[7:0]), 288'(8'hA5));
    check("R10 byte35", 288'(regWin[287:280]), 288'(8'h3C));
    check("R10 others", regWin & ~{8'hFF, 272'd0, 8'hFF}, 288'(0));

    // R9 reset clears state again
    doReset();
    check("R9 regWin after", regWin, 288'(0));
    check("R9 a20 after", 288'(a20Gate), 288'(0));
    access(1'b1, 8'hEC, 8'h00);
    check("R9 pointer after", 288'(lastRd), 288'(0));

    // R6 gate set by read, cleared by write
    access(1'b1, 8'hEE, 8'h00);
    check("R6 set", 288'(a20Gate), 288'(1));
    access(1'b1, 8'hEE, 8'h00);
    check("R6 stays set", 288'(a20Gate), 288'(1));
    access(1'b0, 8'hEE, 8'h5A);
    check("R6 cleared", 288'(a20Gate), 288'(0));
    access(1'b0, 8'hEE, 8'h00);
    check("R6 stays clear", 288'(a20Gate), 288'(0));

    // R7 single pulse after reset-port read
    check("R7 idle", 288'(softRst), 288'(0));
    access(1'b1, 8'hEF, 8'h00);
    check("R7 pulse", 288'(softRst), 288'(1));
    @(negedge clk);
    check("R7 pulse ends", 288'(softRst), 288'(0));
    access(1'b0, 8'hEF, 8'h00);
    check("R7 write no pulse", 288'(softRst), 288'(0));
    access(1'b1, 8'hEE, 8'h00);
    check("R7 gate read no pulse", 288'(softRst), 288'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule